// File: doc/BRIEF.md
# Triggered Latency Pipeline with Event Buffer

This block writes one hit vector into a circular pipeline on every clock. The hit vector is one bit per detector channel. A trigger pointer trails the write pointer by a programmable number of clocks. When a trigger arrives, the row under the trigger pointer is still in the pipeline. The trigger moves that row into a small first-in first-out event buffer. The row is stored together with the pipeline address it was read from. Readout logic downstream sees a valid flag while at least one event is buffered. It takes the oldest event with a pop strobe.

Two error conditions are kept as sticky flags until the next reset:
- Latency error: while the trigger pointer runs, the distance between the two pointers is compared with the latency input on every clock. Any mismatch sets the flag.
- Buffer-full error: a trigger that arrives while the buffer is full is dropped, and the flag is set.

Both pointers wrap modulo the pipeline depth. The distance check uses the same modulo arithmetic.

Top module: `trig_latency_buffer`

## Requirements
- R1: While reset is held, and on the first sampling after reset is applied, `ev_valid`, `lat_err` and `full_err` are low. The write pointer restarts from row 0.
- R2: On every clock edge the hit vector is written into the pipeline. Edges are numbered from 0, starting with the first edge after reset is released; L is the latency input. A trigger sampled at edge n, with n >= L, buffers the hit vector presented at edge n-L. It tags that event with the address (n-L) mod PIPE_DEPTH.
- R3: The trigger pointer stays at row 0 until the write pointer equals L. From that edge onward it advances by one row per clock, modulo PIPE_DEPTH. So a trigger at edge L captures row 0.
- R4: A trigger sampled before the trigger pointer has started is ignored. No event is buffered.
- R5: While the trigger pointer runs, any clock on which (write pointer − trigger pointer) mod PIPE_DEPTH differs from the latency input sets `lat_err`. The flag is visible after that edge. It stays set until reset.
- R6: Events leave the buffer in arrival order. `ev_valid` is high whenever the occupancy is nonzero. `ev_hits` and `ev_addr` show the oldest event.
- R7: A pop while `ev_valid` is high removes the oldest event at that edge. A pop while the buffer is empty has no effect.
- R8: A trigger that arrives while BUF_DEPTH events are stored is dropped. It sets `full_err`, which stays set until reset. The stored events are unchanged.
- R9: A trigger and a pop on the same clock, with the buffer neither empty nor full, leave the occupancy unchanged. The new event is appended after the remaining ones.
- R10: Triggers spaced three clocks apart are all accepted while the buffer has room.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| latency | input | $clog2(PIPE_DEPTH) | Programmed distance between the write and trigger pointers |
| trigger | input | 1 | Captures the row under the trigger pointer into the buffer |
| hits | input | HIT_W | Hit vector written into the pipeline this clock |
| pop | input | 1 | Removes the oldest buffered event |
| ev_hits | output | HIT_W | Hit vector of the oldest buffered event |
| ev_addr | output | $clog2(PIPE_DEPTH) | Pipeline address of the oldest buffered event |
| ev_valid | output | 1 | At least one event is buffered |
| lat_err | output | 1 | Sticky pointer-distance mismatch flag |
| full_err | output | 1 | Sticky flag for a trigger dropped on a full buffer |

## Verification
The bench builds the block with HIT_W=16, PIPE_DEPTH=16, BUF_DEPTH=4 and a latency of 5. With a 16-row pipeline, the pointers wrap several times within the run, so a wrong wrap or a wrong address tag shows up as a data mismatch. The hit pattern is unique for each edge over the whole run. With a four-entry buffer, the full condition, the dropped trigger and a complete drain are each reached within a few dozen clocks. Changing the latency input after start exposes the distance check.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   // Operation applied to the event buffer on one clock: {push, pop}
   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_POP  = 2'b01,
      OP_PUSH = 2'b10,
      OP_BOTH = 2'b11
   } fifo_op_e;
endpackage

// File: rtl/tlb_ptr_ctrl.sv
module tlb_ptr_ctrl #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] latency,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] trig_ptr,
   output logic          running,
   output logic          lat_err
);
   logic started_q;
   logic [AW-1:0] gap;

   // The trigger pointer starts on the edge where the write pointer reaches the latency
   assign running = started_q | (wr_ptr == latency);
   assign gap     = wr_ptr - trig_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr    <= '0;
         trig_ptr  <= '0;
         started_q <= 1'b0;
         lat_err   <= 1'b0;
      end else begin
         wr_ptr <= wr_ptr + 1'b1;
         if (running) begin
            started_q <= 1'b1;
            trig_ptr  <= trig_ptr + 1'b1;
            if (gap != latency) begin
               lat_err <= 1'b1;
            end
         end
      end
   end

   assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (wr_ptr == $past(wr_ptr) + 1'b1));
   assert_trig_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      started_q |=> (trig_ptr == $past(trig_ptr) + 1'b1));
   assert_trig_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !running |=> (trig_ptr == $past(trig_ptr)));
   assert_lat_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lat_err |=> lat_err);
endmodule

// File: rtl/tlb_pipe_mem.sv
module tlb_pipe_mem #(
   parameter int unsigned W     = 128,
   parameter int unsigned DEPTH = 256,
   parameter int unsigned AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic [AW-1:0] wr_addr,
   input  logic [W-1:0]  wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [W-1:0]  rd_data
);
   logic [W-1:0] rows [DEPTH];

   // One row written every clock; the read returns the content before this edge
   always_ff @(posedge clk) begin
      rows[wr_addr] <= wr_data;
   end

   assign rd_data = rows[rd_addr];
endmodule

// File: rtl/tlb_event_fifo.sv
module tlb_event_fifo
   import tlb_pkg::*;
#(
   parameter int unsigned W     = 136,
   parameter int unsigned DEPTH = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         not_empty,
   output logic         overflow
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic [W-1:0]  slots [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] count, cnt_nx;
   logic          full, do_push, do_pop;
   fifo_op_e      op;

   assign full      = (count == CW'(DEPTH));
   assign not_empty = (count != '0);
   assign do_push   = push & ~full;
   assign do_pop    = pop & not_empty;
   assign op        = fifo_op_e'({do_push, do_pop});
   assign dout      = slots[rp];

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
   end else begin : g_wrap
      assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   always_comb begin
      case (op)
         OP_PUSH: cnt_nx = count + 1'b1;
         OP_POP:  cnt_nx = count - 1'b1;
         default: cnt_nx = count;
      endcase
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         slots[wp] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp       <= '0;
         rp       <= '0;
         count    <= '0;
         overflow <= 1'b0;
      end else begin
         count <= cnt_nx;
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         if (push && full) overflow <= 1'b1;
      end
   end

   assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_both_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && not_empty && !full) |=> $stable(count));
   assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !not_empty) |=> !not_empty);
   assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
   assert_full_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && full) |=> $stable(count));
endmodule

// File: rtl/trig_latency_buffer.sv
module trig_latency_buffer #(
   parameter int unsigned HIT_W      = 128,
   parameter int unsigned PIPE_DEPTH = 256,
   parameter int unsigned BUF_DEPTH  = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [$clog2(PIPE_DEPTH)-1:0] latency,
   input  logic                          trigger,
   input  logic [HIT_W-1:0]              hits,
   input  logic                          pop,
   output logic [HIT_W-1:0]              ev_hits,
   output logic [$clog2(PIPE_DEPTH)-1:0] ev_addr,
   output logic                          ev_valid,
   output logic                          lat_err,
   output logic                          full_err
);
   localparam int unsigned AW = $clog2(PIPE_DEPTH);
   localparam int unsigned EW = HIT_W + AW;

   if (PIPE_DEPTH < 2 || (PIPE_DEPTH & (PIPE_DEPTH - 1)) != 0) begin : g_bad_pipe
      $error("PIPE_DEPTH must be a power of two of at least 2");
   end
   if (BUF_DEPTH < 1) begin : g_bad_buf
      $error("BUF_DEPTH must be at least 1");
   end
   if (HIT_W < 1) begin : g_bad_width
      $error("HIT_W must be at least 1");
   end

   logic [AW-1:0]    wr_ptr, trig_ptr;
   logic             run;
   logic [HIT_W-1:0] row;
   logic [EW-1:0]    ev_word;

   tlb_ptr_ctrl #(.DEPTH(PIPE_DEPTH), .AW(AW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .latency  (latency),
      .wr_ptr   (wr_ptr),
      .trig_ptr (trig_ptr),
      .running  (run),
      .lat_err  (lat_err)
   );

   tlb_pipe_mem #(.W(HIT_W), .DEPTH(PIPE_DEPTH), .AW(AW)) u_pipe (
      .clk     (clk),
      .wr_addr (wr_ptr),
      .wr_data (hits),
      .rd_addr (trig_ptr),
      .rd_data (row)
   );

   tlb_event_fifo #(.W(EW), .DEPTH(BUF_DEPTH)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (trigger & run),
      .pop       (pop),
      .din       ({trig_ptr, row}),
      .dout      (ev_word),
      .not_empty (ev_valid),
      .overflow  (full_err)
   );

   assign ev_addr = ev_word[EW-1:HIT_W];
   assign ev_hits = ev_word[HIT_W-1:0];

   assert_early_trig_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (trigger && !run && !pop) |=> $stable(ev_valid));
   assert_full_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      full_err |=> full_err);
endmodule

// File: tb/trig_latency_buffer_tb.sv
module trig_latency_buffer_tb;
   localparam int HW  = 16;
   localparam int PD  = 16;
   localparam int BD  = 4;
   localparam int AW  = 4;
   localparam int LAT = 5;
   // each entry: [5:2] idle clocks before, [1] trigger, [0] pop
   localparam int NTAB = 10;
   localparam logic [5:0] TBL [NTAB] = '{
      {4'd5, 1'b1, 1'b0}, {4'd2, 1'b1, 1'b0}, {4'd2, 1'b1, 1'b1}, {4'd0, 1'b0, 1'b1},
      {4'd2, 1'b1, 1'b0}, {4'd1, 1'b1, 1'b1}, {4'd3, 1'b0, 1'b1}, {4'd2, 1'b1, 1'b1},
      {4'd9, 1'b1, 1'b0}, {4'd0, 1'b0, 1'b1}
   };

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n;
   logic [AW-1:0] latency;
   logic          trigger, pop;
   logic [HW-1:0] hits;
   logic [HW-1:0] ev_hits;
   logic [AW-1:0] ev_addr;
   logic          ev_valid, lat_err, full_err;

   int checks = 0;
   int errors = 0;
   int n = 0;
   logic [HW-1:0] q_hits [64];
   logic [AW-1:0] q_addr [64];
   int qh = 0, qt = 0, mcnt = 0;
   bit mfull = 1'b0;

   trig_latency_buffer #(.HIT_W(HW), .PIPE_DEPTH(PD), .BUF_DEPTH(BD)) u_dut (
      .clk (clk), .rst_n (rst_n), .latency (latency), .trigger (trigger),
      .hits (hits), .pop (pop), .ev_hits (ev_hits), .ev_addr (ev_addr),
      .ev_valid (ev_valid), .lat_err (lat_err), .full_err (full_err)
   );

   function automatic logic [HW-1:0] pat(input int e);
      return HW'((e * 29 + 7) ^ (e << 6));
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // called at a negedge; drives one clock and returns at the next negedge
   task automatic step(input bit t, input bit p, input string req);
      int pre;
      chk(ev_valid == (mcnt != 0), req, "ev_valid", int'(ev_valid), int'(mcnt != 0));
      chk(full_err == mfull, req, "full_err", int'(full_err), int'(mfull));
      if (p && mcnt > 0) begin
         chk(ev_hits == q_hits[qh % 64], req, "ev_hits", int'(ev_hits), int'(q_hits[qh % 64]));
         chk(ev_addr == q_addr[qh % 64], req, "ev_addr", int'(ev_addr), int'(q_addr[qh % 64]));
      end
      trigger = t;
      pop     = p;
      hits    = pat(n);
      @(posedge clk);
      pre = mcnt;
      if (t && n >= LAT) begin
         if (pre < BD) begin
            q_hits[qt % 64] = pat(n - LAT);
            q_addr[qt % 64] = AW'((n - LAT) % PD);
            qt++;
            mcnt++;
         end else begin
            mfull = 1'b1;
         end
      end
      if (p && pre > 0) begin
         qh++;
         mcnt--;
      end
      n++;
      @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; latency = AW'(LAT); trigger = 1'b0; pop = 1'b0; hits = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(ev_valid == 1'b0, "R1", "ev_valid", int'(ev_valid), 0);
      chk(lat_err == 1'b0, "R1", "lat_err", int'(lat_err), 0);
      chk(full_err == 1'b0, "R1", "full_err", int'(full_err), 0);
      rst_n = 1'b1;
      n = 0;
      // R4: triggers before the trigger pointer starts are ignored
      step(1'b1, 1'b0, "R4");
      step(1'b1, 1'b0, "R4");
      step(1'b1, 1'b0, "R4");
      step(1'b0, 1'b0, "R4");
      step(1'b1, 1'b0, "R4");
      // R3: trigger exactly at edge LAT captures row 0
      step(1'b1, 1'b0, "R3");
      step(1'b0, 1'b1, "R3 R2");
      // table walk: R2 R6 R9 R10
      for (int i = 0; i < NTAB; i++) begin
         for (int g = 0; g < int'(TBL[i][5:2]); g++) step(1'b0, 1'b0, "R6");
         step(TBL[i][1], TBL[i][0], "R2 R9 R10");
      end
      while (mcnt > 0) step(1'b0, 1'b1, "R6 R7");
      step(1'b0, 1'b0, "R6");
      // R8: overflow drops the fifth trigger and sets the sticky flag
      for (int i = 0; i < BD + 1; i++) begin
         step(1'b1, 1'b0, "R8 R10");
         step(1'b0, 1'b0, "R8");
         step(1'b0, 1'b0, "R8");
      end
      while (mcnt > 0) step(1'b0, 1'b1, "R8 R6");
      // R7: pop on empty buffer has no effect
      step(1'b0, 1'b1, "R7");
      step(1'b0, 1'b0, "R7");
      step(1'b1, 1'b0, "R7");
      step(1'b0, 1'b1, "R7");
      step(1'b0, 1'b0, "R7");
      // R5: latency mismatch sets the sticky error
      chk(lat_err == 1'b0, "R5", "lat_err before change", int'(lat_err), 0);
      latency = AW'(LAT + 1);
      step(1'b0, 1'b0, "R5");
      chk(lat_err == 1'b1, "R5", "lat_err after change", int'(lat_err), 1);
      latency = AW'(LAT);
      step(1'b0, 1'b0, "R5");
      chk(lat_err == 1'b1, "R5", "lat_err sticky", int'(lat_err), 1);
      // R1: reset clears the flags
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(ev_valid == 1'b0, "R1", "ev_valid after reset", int'(ev_valid), 0);
      chk(lat_err == 1'b0, "R1", "lat_err after reset", int'(lat_err), 0);
      chk(full_err == 1'b0, "R1", "full_err after reset", int'(full_err), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule